// File: doc/BRIEF.md
# Timeout and Break-Even Power State Controller

This block decides when a processor-like subsystem drops from full operation into a light idle mode or into deep sleep, and sequences each move with a latency countdown. It watches an activity input and a wake request. It enters idle as soon as activity stops. It then decides whether to go further into sleep. Under the timeout policy it sleeps once idle has lasted a programmed number of cycles. Under the predictive policy it sleeps at once only when a supplied predicted idle length is greater than the break-even time; otherwise it stays in idle.

Every change of mode passes through a transition whose length in cycles comes from a programmable latency value. Four latencies are used: run to idle, idle to run, idle to sleep and sleep to run. A wake request that arrives during an entry transition is held and acted on when that transition ends. The block counts sleep entries. It also counts wrong shutdowns, meaning sleeps that were ended by a wake before the break-even time had passed. Configuration is written through a small write port. Values are staged and only take effect at the next run-to-idle move.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the mode output is run (00), the transition flag is low, and both event counts are zero.
- R2: The mode output reads 00 in run, 01 in idle, 10 in sleep and 11 during any transition. The transition flag is high exactly when the mode reads 11.
- R3: In run with activity low and no wake request, the block enters a run-to-idle transition that lasts the staged run-to-idle latency in cycles (a latency of 0 acts as 1) and then shows idle.
- R4: In idle, activity high or a wake request starts an idle-to-run transition of the idle-to-run latency, after which the mode is run.
- R5: With policy word 0 (timeout policy), idle that lasts the timeout value in cycles with no exit cause starts an idle-to-sleep transition of the idle-to-sleep latency, which ends in sleep.
- R6: With a nonzero policy word (predictive policy), the first idle cycle starts the idle-to-sleep transition when the predicted idle length is strictly greater than break-even; otherwise the block stays in idle regardless of the timeout.
- R7: In sleep, activity has no effect. Only a wake request starts the sleep-to-run transition of the sleep-to-run latency, which ends in run.
- R8: A wake request seen during a run-to-idle or idle-to-sleep transition is held. The target mode is then shown for exactly one cycle before the matching exit transition begins.
- R9: The sleep count rises by one in the cycle the mode first reads sleep, and saturates at its maximum.
- R10: When a wakeup leaves sleep after fewer cycles in sleep than the break-even value (the cycle that sees the wake counts as one), the wrong-shutdown count rises by one. At break-even or above it is unchanged.
- R11: Configuration writes use address 0 policy, 1 timeout, 2 break-even, 3 run-to-idle latency, 4 idle-to-run latency, 5 idle-to-sleep latency, 6 sleep-to-run latency; address 7 is ignored. A write only affects behaviour from the next run-to-idle move onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_busy | input | 1 | Subsystem activity, high while work is present |
| wake_req | input | 1 | Wake request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | CW | Configuration write data |
| pred_idle | input | CW | Predicted idle length in cycles |
| pm_mode | output | 2 | Current mode code |
| xfer_busy | output | 1 | High during any transition |
| sleep_count | output | EW | Number of sleep entries |
| wrong_count | output | EW | Number of wrong shutdowns |

## Verification
The bench builds the block with one cycle per microsecond, a 24-bit configuration width and 16-bit counters. It then programs latencies of a few cycles and a break-even of 8. Every transition, the timeout expiry, both predictive outcomes, latched wakes in both entry transitions and the break-even boundary on either side can then be reached within a few hundred cycles. The full-scale reset latencies would need 160,000 cycles for one wakeup. A behavioural model steps alongside the design and is compared on every cycle.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes: seven configuration words, indexed as listed below.
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_SLEEP,
        ST_ENT_IDLE,
        ST_EXIT_IDLE,
        ST_ENT_SLEEP,
        ST_EXIT_SLEEP
    } pm_state_e;

    localparam int NCFG   = 7;
    localparam int CI_POL = 0;
    localparam int CI_TMO = 1;
    localparam int CI_BE  = 2;
    localparam int CI_LRI = 3;
    localparam int CI_LIR = 4;
    localparam int CI_LRS = 5;
    localparam int CI_LSR = 6;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_IDLE  = 2'b01;
    localparam logic [1:0] MODE_SLEEP = 2'b10;
    localparam logic [1:0] MODE_XFER  = 2'b11;

endpackage

// File: rtl/pmc_cfg_regs.sv
// Staged and live configuration words.
// Writes land in the staged copy; the live copy takes the staged words
// when snap is pulsed (run-to-idle move). Assumes addresses >= NCFG are dropped.
module pmc_cfg_regs
    import pmc_pkg::*;
#(
    parameter int CW = 24,
    parameter logic [NCFG-1:0][CW-1:0] RST_VAL = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [2:0]                addr,
    input  logic [CW-1:0]             wdata,
    input  logic                      snap,
    output logic [CW-1:0]             stage_lri,
    output logic [NCFG-1:0][CW-1:0]   live
);

    logic [NCFG-1:0][CW-1:0] stage_q;

    for (genvar g = 0; g < NCFG; g++) begin : g_word
        // Staged word: written from the port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= RST_VAL[g];
            else if (we && addr == 3'(g))
                stage_q[g] <= wdata;
        end

        // Live word: copied from staging at idle entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live[g] <= RST_VAL[g];
            else if (snap)
                live[g] <= stage_q[g];
        end
    end

    assign stage_lri = stage_q[CI_LRI];

    // R11
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(live));

endmodule

// File: rtl/pmc_lat_timer.sv
// Transition latency down-counter.
// load captures a latency (0 treated as 1); while run is high the count
// falls to 1, and done is high when the count is at or below 1.
module pmc_lat_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load or count down the remaining transition cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(1);
        else if (load)
            cnt_q <= (load_val == '0) ? CW'(1) : load_val;
        else if (run && cnt_q > CW'(1))
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q <= CW'(1));

    // R3
    zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q != '0);

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/pmc_evt_ctr.sv
// Saturating event counter: adds one per inc pulse, holds at all ones.
module pmc_evt_ctr #(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [EW-1:0] count
);

    // Count events without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != '1)
            count <= count + EW'(1);
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count == '1 |=> count == '1);

    // R10
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> count == $past(count) + EW'(1));

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller: run / idle / sleep with timed transitions.
// Decides idle and sleep entry from activity, wake, timeout or predicted
// idle length, runs the transitions through a latency timer and counts
// sleeps and premature wakeups. Assumes inputs are synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CW         = 24,
    parameter int EW         = 16,
    parameter int CYC_PER_US = 100,
    parameter int TMO_US     = 2000,
    parameter int BE_US      = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_busy,
    input  logic          wake_req,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic [CW-1:0] pred_idle,
    output logic [1:0]    pm_mode,
    output logic          xfer_busy,
    output logic [EW-1:0] sleep_count,
    output logic [EW-1:0] wrong_count
);

    localparam logic [CW-1:0] RV_POL = '0;
    localparam logic [CW-1:0] RV_TMO = CW'(TMO_US * CYC_PER_US);
    localparam logic [CW-1:0] RV_BE  = CW'(BE_US * CYC_PER_US);
    localparam logic [CW-1:0] RV_LRI = CW'(10 * CYC_PER_US);
    localparam logic [CW-1:0] RV_LIR = CW'(10 * CYC_PER_US);
    localparam logic [CW-1:0] RV_LRS = CW'(90 * CYC_PER_US);
    localparam logic [CW-1:0] RV_LSR = CW'(160000 * CYC_PER_US);
    localparam logic [NCFG-1:0][CW-1:0] CFG_RST =
        {RV_LSR, RV_LRS, RV_LIR, RV_LRI, RV_BE, RV_TMO, RV_POL};

    pm_state_e               st_q, st_n;
    logic [NCFG-1:0][CW-1:0] live;
    logic [CW-1:0]           stage_lri;
    logic [CW-1:0]           dwell_q;
    logic                    pend_q;
    logic                    snap, tmr_load, tmr_done, in_xfer;
    logic [CW-1:0]           tmr_val;
    logic                    shut_inc, wrong_inc;
    logic                    go_sleep, short_sleep, predictive;

    pmc_cfg_regs #(.CW(CW), .RST_VAL(CFG_RST)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .snap      (snap),
        .stage_lri (stage_lri),
        .live      (live)
    );

    pmc_lat_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (in_xfer),
        .done     (tmr_done)
    );

    pmc_evt_ctr #(.EW(EW)) u_shut_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (shut_inc),
        .count (sleep_count)
    );

    pmc_evt_ctr #(.EW(EW)) u_wrong_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wrong_inc),
        .count (wrong_count)
    );

    assign in_xfer     = (st_q == ST_ENT_IDLE) || (st_q == ST_EXIT_IDLE) ||
                         (st_q == ST_ENT_SLEEP) || (st_q == ST_EXIT_SLEEP);
    assign predictive  = (live[CI_POL] != '0);
    assign go_sleep    = predictive
                       ? (dwell_q == '0 && pred_idle > live[CI_BE])
                       : ({1'b0, dwell_q} + (CW+1)'(1) >= {1'b0, live[CI_TMO]});
    assign short_sleep = ({1'b0, dwell_q} + (CW+1)'(1)) < {1'b0, live[CI_BE]};

    // Next mode and side effects for the current cycle.
    always_comb begin
        st_n      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        snap      = 1'b0;
        shut_inc  = 1'b0;
        wrong_inc = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (!act_busy && !wake_req) begin
                    st_n     = ST_ENT_IDLE;
                    tmr_load = 1'b1;
                    tmr_val  = stage_lri;
                    snap     = 1'b1;
                end
            end
            ST_ENT_IDLE: begin
                if (tmr_done) st_n = ST_IDLE;
            end
            ST_IDLE: begin
                if (act_busy || wake_req || pend_q) begin
                    st_n     = ST_EXIT_IDLE;
                    tmr_load = 1'b1;
                    tmr_val  = live[CI_LIR];
                end else if (go_sleep) begin
                    st_n     = ST_ENT_SLEEP;
                    tmr_load = 1'b1;
                    tmr_val  = live[CI_LRS];
                end
            end
            ST_ENT_SLEEP: begin
                if (tmr_done) begin
                    st_n     = ST_SLEEP;
                    shut_inc = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_req || pend_q) begin
                    st_n      = ST_EXIT_SLEEP;
                    tmr_load  = 1'b1;
                    tmr_val   = live[CI_LSR];
                    wrong_inc = short_sleep;
                end
            end
            ST_EXIT_IDLE, ST_EXIT_SLEEP: begin
                if (tmr_done) st_n = ST_RUN;
            end
            default: st_n = ST_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_n;
    end

    // Cycles spent in the current mode, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              dwell_q <= '0;
        else if (st_n != st_q)   dwell_q <= '0;
        else if (dwell_q != '1)  dwell_q <= dwell_q + CW'(1);
    end

    // Wake held across entry transitions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (st_q == ST_ENT_IDLE || st_q == ST_ENT_SLEEP)
            pend_q <= pend_q | wake_req;
        else
            pend_q <= 1'b0;
    end

    // Mode code and transition flag.
    always_comb begin
        case (st_q)
            ST_RUN:   pm_mode = MODE_RUN;
            ST_IDLE:  pm_mode = MODE_IDLE;
            ST_SLEEP: pm_mode = MODE_SLEEP;
            default:  pm_mode = MODE_XFER;
        endcase
    end
    assign xfer_busy = in_xfer;

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && !wake_req && !pend_q) |=> st_q == ST_SLEEP);

    // R4
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && act_busy) |=> st_q == ST_EXIT_IDLE);

    // R8
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ENT_IDLE || st_q == ST_ENT_SLEEP) && wake_req) |=> pend_q);

    // R9
    shut_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sleep_count) |-> (st_q == ST_SLEEP && $past(st_q) == ST_ENT_SLEEP));

    // R10
    wrong_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wrong_count) |-> (st_q == ST_EXIT_SLEEP && $past(st_q) == ST_SLEEP));

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

    localparam int CW = 24;
    localparam int EW = 16;
    localparam int CPU = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_busy = 1'b1;
    logic          wake_req = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] pred_idle = '0;
    logic [1:0]    pm_mode;
    logic          xfer_busy;
    logic [EW-1:0] sleep_count;
    logic [EW-1:0] wrong_count;

    pwr_mode_ctrl #(.CW(CW), .EW(EW), .CYC_PER_US(CPU), .TMO_US(2000), .BE_US(300))
    u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .act_busy(act_busy), .wake_req(wake_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pred_idle(pred_idle), .pm_mode(pm_mode), .xfer_busy(xfer_busy),
        .sleep_count(sleep_count), .wrong_count(wrong_count)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done_run = 0;

    // Reference model: 0 run, 1 idle, 2 sleep, 3 enter idle, 4 exit idle,
    // 5 enter sleep, 6 exit sleep.
    int m_st, m_cnt, m_dwell, m_pend, m_shut, m_wrong;
    int stg[7];
    int sh[7];

    function automatic int atleast1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int mode_of(int s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_cnt = 1; m_dwell = 0; m_pend = 0; m_shut = 0; m_wrong = 0;
        stg[0] = 0; stg[1] = 2000 * CPU; stg[2] = 300 * CPU; stg[3] = 10 * CPU;
        stg[4] = 10 * CPU; stg[5] = 90 * CPU; stg[6] = 160000 * CPU;
        foreach (sh[i]) sh[i] = stg[i];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int ns;
            int np;
            ns = m_st;
            np = 0;
            case (m_st)
                0: if (!act_busy && !wake_req) begin
                       foreach (sh[i]) sh[i] = stg[i];
                       m_cnt = atleast1(stg[3]); ns = 3;
                   end
                3: begin
                       np = m_pend | wake_req;
                       if (m_cnt <= 1) ns = 1; else m_cnt--;
                   end
                1: begin
                       if (act_busy || wake_req || m_pend) begin
                           ns = 4; m_cnt = atleast1(sh[4]);
                       end else if ((sh[0] != 0) ? (m_dwell == 0 && int'(pred_idle) > sh[2])
                                                 : (m_dwell + 1 >= sh[1])) begin
                           ns = 5; m_cnt = atleast1(sh[5]);
                       end
                   end
                5: begin
                       np = m_pend | wake_req;
                       if (m_cnt <= 1) begin ns = 2; m_shut++; end else m_cnt--;
                   end
                2: if (wake_req || m_pend) begin
                       if (m_dwell + 1 < sh[2]) m_wrong++;
                       ns = 6; m_cnt = atleast1(sh[6]);
                   end
                default: if (m_cnt <= 1) ns = 0; else m_cnt--;
            endcase
            if (ns != m_st) m_dwell = 0; else m_dwell++;
            m_st = ns;
            m_pend = np;
            if (cfg_we && cfg_addr < 3'd7) stg[cfg_addr] = int'(cfg_wdata);
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            vectors++;
            if (int'(pm_mode) != mode_of(m_st)) begin
                miscompares++;
                $display("FAIL R2 mode actual=%0d expected=%0d", pm_mode, mode_of(m_st));
            end
            if (xfer_busy != (mode_of(m_st) == 3)) begin
                miscompares++;
                $display("FAIL R2 busy actual=%0d expected=%0d", xfer_busy, mode_of(m_st) == 3);
            end
            if (int'(sleep_count) != m_shut) begin
                miscompares++;
                $display("FAIL R9 sleeps actual=%0d expected=%0d", sleep_count, m_shut);
            end
            if (int'(wrong_count) != m_wrong) begin
                miscompares++;
                $display("FAIL R10 wrong actual=%0d expected=%0d", wrong_count, m_wrong);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000 && !done_run) begin
            miscompares++;
            $display("FAIL watchdog R1..: actual=%0d cycles expected=fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic cfg_write(int a, int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = CW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_mode(int val, output int n);
        n = 0;
        while (int'(pm_mode) == val && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_trans(int exp, string tag);
        int w;
        int n;
        w = 0;
        while (pm_mode != 2'b11 && w < 100) begin
            @(negedge clk);
            w++;
        end
        count_mode(3, n);
        check(n == exp, tag, n, exp);
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        int n;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(pm_mode == 2'b00, "R1 mode", pm_mode, 0);
        check(xfer_busy == 1'b0, "R1 busy", xfer_busy, 0);
        check(sleep_count == 0 && wrong_count == 0, "R1 counts", sleep_count + wrong_count, 0);

        // R11 program the configuration words
        cfg_write(0, 0); cfg_write(1, 5); cfg_write(2, 8); cfg_write(3, 3);
        cfg_write(4, 2); cfg_write(5, 4); cfg_write(6, 6); cfg_write(7, 1);

        // R3 / R4: idle entry and early exit
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        check(pm_mode == 2'b01, "R3 idle shown", pm_mode, 1);
        @(negedge clk);
        act_busy = 1'b1;
        run_trans(2, "R4 exit idle");
        check(pm_mode == 2'b00, "R4 back in run", pm_mode, 0);

        // R5 timeout to sleep, R7 activity ignored in sleep
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        count_mode(1, n);
        check(n == 5, "R5 idle length", n, 5);
        run_trans(4, "R5 enter sleep");
        check(pm_mode == 2'b10, "R5 sleep shown", pm_mode, 2);
        check(sleep_count == 1, "R9 first sleep", sleep_count, 1);
        for (int i = 0; i < 20; i++) begin
            act_busy = i[0];
            @(negedge clk);
            check(pm_mode == 2'b10, "R7 activity ignored", pm_mode, 2);
        end
        act_busy = 1'b1;
        pulse_wake();
        run_trans(6, "R7 wakeup");
        check(pm_mode == 2'b00, "R7 run after wake", pm_mode, 0);
        check(wrong_count == 0, "R10 long sleep", wrong_count, 0);

        // R10 premature wakeup
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        count_mode(1, n);
        run_trans(4, "R5 enter sleep");
        @(negedge clk);
        act_busy = 1'b1;
        pulse_wake();
        run_trans(6, "R7 wakeup");
        check(wrong_count == 1, "R10 short sleep", wrong_count, 1);
        check(sleep_count == 2, "R9 second sleep", sleep_count, 2);

        // R8 wake held during idle entry
        act_busy = 1'b0;
        @(negedge clk);
        pulse_wake();
        run_trans(2, "R8 rest of idle entry");
        count_mode(1, n);
        check(n == 1, "R8 idle one cycle", n, 1);
        run_trans(2, "R4 exit idle");
        act_busy = 1'b1;

        // R8 wake held during sleep entry
        @(negedge clk);
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        count_mode(1, n);
        pulse_wake();
        run_trans(3, "R8 rest of sleep entry");
        count_mode(2, n);
        check(n == 1, "R8 sleep one cycle", n, 1);
        act_busy = 1'b1;
        run_trans(6, "R7 wakeup");
        check(wrong_count == 2, "R10 held wake", wrong_count, 2);
        check(sleep_count == 3, "R9 third sleep", sleep_count, 3);

        // R6 predictive, short prediction stays idle; R11 staged write
        cfg_write(0, 1);
        pred_idle = CW'(3);
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        for (int i = 0; i < 30; i++) begin
            check(pm_mode == 2'b01, "R6 stays idle", pm_mode, 1);
            @(negedge clk);
        end
        cfg_write(4, 9);
        act_busy = 1'b1;
        run_trans(2, "R11 old latency kept");
        check(pm_mode == 2'b00, "R4 back in run", pm_mode, 0);

        // R6 long prediction sleeps at once; R10 boundary at break-even
        pred_idle = CW'(20);
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        count_mode(1, n);
        check(n == 1, "R6 sleep on first idle cycle", n, 1);
        run_trans(4, "R6 enter sleep");
        repeat (7) @(negedge clk);
        act_busy = 1'b1;
        pulse_wake();
        run_trans(6, "R7 wakeup");
        check(wrong_count == 2, "R10 break-even boundary", wrong_count, 2);
        check(sleep_count == 4, "R9 fourth sleep", sleep_count, 4);

        // R11 new idle-exit latency now applies
        pred_idle = CW'(3);
        act_busy = 1'b0;
        run_trans(3, "R3 enter idle");
        @(negedge clk);
        act_busy = 1'b1;
        run_trans(9, "R11 new latency");

        // R3 zero latency acts as one cycle
        cfg_write(3, 0);
        act_busy = 1'b0;
        run_trans(1, "R3 zero latency");
        check(pm_mode == 2'b01, "R3 idle shown", pm_mode, 1);
        act_busy = 1'b1;
        run_trans(9, "R4 exit idle");

        repeat (3) @(negedge clk);
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule